// File: doc/BRIEF.md
# Instruction Mix Counter

This block watches the stream of retiring 32-bit instruction words. Each word comes with a valid strobe and its program counter. The block sorts every qualifying instruction into one of five categories and adds one to that category's counter, so an operating system can read the mix of instruction kinds that the running thread executes.

The category comes from a programmable table, not from a fixed decoder. The table index is the major op field, bits 31:30, joined to the sub-opcode field that the major op selects. Counting runs only while the global enable is high. It can also be limited to an inclusive PC window. The table can be rewritten while counting is stopped. Software reads one counter at a time through a registered read port, and a single clear input zeroes the whole counter bank.

Top module: `instr_mix_counter`

## Requirements
- R1: After reset every counter is 0, `rd_data` is 0, and every table entry holds the category code 4 (other).
- R2: The 8-bit table index is `{instr[31:30], sub}`. When major op is 0, `sub` is `{3'b000, instr[24:22]}`. When major op is 1, `sub` is 0. When major op is 2 or 3, `sub` is `instr[24:19]`. No other bits of the word affect the index.
- R3: A qualifying instruction adds one to exactly one counter, the one selected by its table entry. Category codes are 0 memory, 1 floating point, 2 control flow, 3 integer, 4 other, and stored codes 5 to 7 count as 4. The counter moves at the clock edge where the instruction is presented.
- R4: No counter changes when `retire_valid` is low or `count_en` is low.
- R5: With `win_en` high, an instruction counts only if `win_lo <= retire_pc <= win_hi`, both bounds included. With `win_en` low, the PC is not checked.
- R6: A table write (`tbl_we`) is accepted only while `count_en` is low and applies to instructions in later cycles. While `count_en` is high the write is ignored.
- R7: Each counter saturates at its all-ones value and holds there.
- R8: `clr` zeroes all five counters at the next edge and wins over an increment in the same cycle.
- R9: At each edge `rd_data` loads the value the counter selected by `rd_sel` held before that edge. A `rd_sel` of 5, 6 or 7 loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_valid | input | 1 | Strobe for a retiring instruction |
| retire_instr | input | 32 | Retiring instruction word |
| retire_pc | input | ADDR_W | PC of the retiring instruction |
| count_en | input | 1 | Global counting enable; also locks the table |
| win_en | input | 1 | Restrict counting to the PC window |
| win_lo | input | ADDR_W | Lowest PC in the window |
| win_hi | input | ADDR_W | Highest PC in the window |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 8 | Table entry to write |
| tbl_cat | input | 3 | Category code to store |
| clr | input | 1 | Zero all counters |
| rd_sel | input | 3 | Counter to read |
| rd_data | output | CNT_W | Registered counter read value |

## Verification
Two situations are hard to reach from the ports. The first is saturation, because a 32-bit counter can never be filled in a test. The bench therefore builds the block with 6-bit counters and retires 70 integer instructions back to back, which drives one counter past its ceiling while the other four stay at 0. The second is the set of same-cycle collisions: a clear together with a valid instruction, a table write while counting is enabled, and a read of the counter that is being incremented in that cycle. The bench sets up each of these on purpose and observes the result through `rd_data`.

// File: rtl/imix_pkg.sv
package imix_pkg;
    localparam int OP_W    = 2;
    localparam int SUB_W   = 6;
    localparam int IDX_W   = OP_W + SUB_W;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int CAT_W   = 3;
    localparam int NUM_CAT = 5;
    localparam int SEL_W   = 3;

    typedef enum logic [CAT_W-1:0] {
        CAT_MEM   = 3'd0,
        CAT_FP    = 3'd1,
        CAT_CTRL  = 3'd2,
        CAT_ALU   = 3'd3,
        CAT_OTHER = 3'd4
    } cat_e;
endpackage

// File: rtl/imix_index.sv
module imix_index
    import imix_pkg::*;
(
    input  logic [31:0]      instr,
    output logic [IDX_W-1:0] idx
);
    logic [OP_W-1:0]  op;
    logic [SUB_W-1:0] sub;
    logic             unused_low;

    assign op         = instr[31:30];
    assign unused_low = ^instr[18:0];

    always_comb begin
        case (op)
            2'd0:    sub = {3'b000, instr[24:22]};
            2'd1:    sub = '0;
            default: sub = instr[24:19];
        endcase
        idx = {op, sub};
    end
endmodule

// File: rtl/imix_table.sv
module imix_table
    import imix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CAT_W-1:0] wr_cat,
    input  logic [IDX_W-1:0] rd_idx,
    output cat_e             rd_cat
);
    typedef struct packed {
        logic [DEPTH-1:0][CAT_W-1:0] ent;
    } tbl_s;

    tbl_s s_d, s_q;
    logic [CAT_W-1:0] raw;

    always_comb begin
        s_d = s_q;
        if (we && !lock) begin
            s_d.ent[wr_idx] = wr_cat;
        end
        raw    = s_q.ent[rd_idx];
        rd_cat = (raw < CAT_W'(NUM_CAT)) ? cat_e'(raw) : CAT_OTHER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                s_q.ent[i] <= CAT_OTHER;
            end
        end else begin
            s_q <= s_d;
        end
    end

    // R6: while counting is on, the table must not change
    assert_table_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(s_q.ent));
endmodule

// File: rtl/imix_counters.sv
module imix_counters
    import imix_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            inc_en,
    input  cat_e                            inc_cat,
    input  logic                            clr,
    output logic [NUM_CAT-1:0][CNT_W-1:0]   cnt_o
);
    typedef struct packed {
        logic [NUM_CAT-1:0][CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s s_d, s_q;
    logic [NUM_CAT-1:0] hit;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_CAT; i++) begin
            hit[i] = inc_en && (inc_cat == cat_e'(CAT_W'(i)));
            if (clr) begin
                s_d.cnt[i] = '0;
            end else if (hit[i] && (s_q.cnt[i] != '1)) begin
                s_d.cnt[i] = s_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    // R3: at most one category is selected per cycle
    assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R4: with no qualified instruction and no clear, the bank holds
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc_en) |=> $stable(s_q.cnt));

    // R8: a clear empties the whole bank
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0));

    for (genvar g = 0; g < NUM_CAT; g++) begin : g_sat
        // R7: a full counter stays full until cleared
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && (s_q.cnt[g] == '1)) |=> (s_q.cnt[g] == '1));
    end
endmodule

// File: rtl/instr_mix_counter.sv
module instr_mix_counter
    import imix_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_valid,
    input  logic [31:0]       retire_instr,
    input  logic [ADDR_W-1:0] retire_pc,
    input  logic              count_en,
    input  logic              win_en,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [CAT_W-1:0]  tbl_cat,
    input  logic              clr,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CNT_W-1:0]  rd_data
);
    typedef struct packed {
        logic [CNT_W-1:0] rd_data;
    } top_s;

    top_s s_d, s_q;
    logic [IDX_W-1:0]             idx;
    cat_e                         cat;
    logic                         in_win;
    logic                         qual;
    logic [NUM_CAT-1:0][CNT_W-1:0] cnt_bus;

    imix_index u_index (
        .instr (retire_instr),
        .idx   (idx)
    );

    imix_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock   (count_en),
        .we     (tbl_we),
        .wr_idx (tbl_idx),
        .wr_cat (tbl_cat),
        .rd_idx (idx),
        .rd_cat (cat)
    );

    imix_counters #(.CNT_W(CNT_W)) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (qual),
        .inc_cat (cat),
        .clr     (clr),
        .cnt_o   (cnt_bus)
    );

    always_comb begin
        in_win = !win_en || ((retire_pc >= win_lo) && (retire_pc <= win_hi));
        qual   = retire_valid && count_en && in_win;
        s_d    = s_q;
        s_d.rd_data = '0;
        for (int i = 0; i < NUM_CAT; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                s_d.rd_data = cnt_bus[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd_data;

    // R9: read port shows the selected counter one edge late
    assert_read_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel < SEL_W'(NUM_CAT)) |=> (rd_data == $past(cnt_bus[rd_sel])));

    // R9: unused selector codes read as zero
    assert_read_void_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel >= SEL_W'(NUM_CAT)) |=> (rd_data == '0));

    // R5: an instruction outside an active window leaves the bank alone
    assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && win_en && (retire_pc > win_hi)) |=> $stable(cnt_bus));
endmodule

// File: tb/instr_mix_counter_test.sv
module instr_mix_counter_test;
    localparam int TB_CNT_W = 6;
    localparam int TB_MAX   = (1 << TB_CNT_W) - 1;

    typedef struct packed {
        logic [1:0] op;
        logic [5:0] fld;
        logic [2:0] cat;
    } vec_t;

    // op, sub-field, expected category (after the table is programmed)
    localparam vec_t [8:0] VECS = '{
        '{2'd3, 6'h00, 3'd0},
        '{2'd3, 6'h04, 3'd0},
        '{2'd2, 6'h34, 3'd1},
        '{2'd1, 6'h2a, 3'd2},
        '{2'd0, 6'h02, 3'd2},
        '{2'd2, 6'h38, 3'd2},
        '{2'd2, 6'h00, 3'd3},
        '{2'd2, 6'h01, 3'd4},
        '{2'd0, 6'h04, 3'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              retire_valid = 1'b0;
    logic [31:0]       retire_instr = '0;
    logic [31:0]       retire_pc = '0;
    logic              count_en = 1'b0;
    logic              win_en = 1'b0;
    logic [31:0]       win_lo = '0;
    logic [31:0]       win_hi = '0;
    logic              tbl_we = 1'b0;
    logic [7:0]        tbl_idx = '0;
    logic [2:0]        tbl_cat = '0;
    logic              clr = 1'b0;
    logic [2:0]        rd_sel = '0;
    logic [TB_CNT_W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] got;

    always #10 clk = ~clk;

    instr_mix_counter #(.CNT_W(TB_CNT_W), .ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid),
        .retire_instr(retire_instr), .retire_pc(retire_pc),
        .count_en(count_en), .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_cat(tbl_cat),
        .clr(clr), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [5:0] fld);
        case (op)
            2'd0:    mk = {2'b00, 5'b10101, fld[2:0], 22'h2aaaaa};
            2'd1:    mk = {2'b01, 30'h15555555};
            default: mk = {op, 5'b10101, fld, 19'h5a5a5};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic send(input logic [31:0] ins, input logic [31:0] pc);
        @(negedge clk);
        retire_valid = 1'b1; retire_instr = ins; retire_pc = pc;
        @(negedge clk);
        retire_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        rd_sel = sel;
        @(posedge clk);
        #1 v = 32'(rd_data);
    endtask

    task automatic clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic prog(input logic [7:0] idx, input logic [2:0] cat);
        @(negedge clk); tbl_we = 1'b1; tbl_idx = idx; tbl_cat = cat;
        @(negedge clk); tbl_we = 1'b0;
    endtask

    task automatic expect_only(input string req, input int cat, input logic [31:0] n);
        logic [31:0] v;
        for (int c = 0; c < 5; c++) begin
            rd(3'(c), v);
            check(req, v, (c == cat) ? n : 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 rd_data at reset", 32'(rd_data), 0);
        @(negedge clk); rst_n = 1'b1;
        expect_only("R1 counters zero", 0, 0);

        // R1: unprogrammed table sends everything to other
        count_en = 1'b1;
        send(mk(2'd3, 6'h00), 32'h0);
        expect_only("R1 default category other", 4, 1);

        // program table while stopped
        count_en = 1'b0;
        prog(8'hc0, 3'd0); prog(8'hc4, 3'd0); prog(8'hb4, 3'd1);
        prog(8'h40, 3'd2); prog(8'h02, 3'd2); prog(8'hb8, 3'd2);
        prog(8'h80, 3'd3); prog(8'h81, 3'd6);
        count_en = 1'b1;

        // R2/R3 vector walk
        for (int k = 0; k < 9; k++) begin
            clear();
            send(mk(VECS[k].op, VECS[k].fld), 32'h0);
            expect_only("R2 R3 vector", int'(VECS[k].cat), 1);
        end

        // R4: gated by valid and by enable
        clear();
        count_en = 1'b0;
        send(mk(2'd2, 6'h00), 32'h0);
        count_en = 1'b1;
        @(negedge clk); retire_valid = 1'b0; retire_instr = mk(2'd2, 6'h00);
        @(negedge clk);
        expect_only("R4 no count when stopped or invalid", 3, 0);

        // R5: PC window bounds
        clear();
        win_en = 1'b1; win_lo = 32'h100; win_hi = 32'h1ff;
        send(mk(2'd2, 6'h00), 32'h100);
        send(mk(2'd2, 6'h00), 32'h1ff);
        send(mk(2'd2, 6'h00), 32'h0ff);
        send(mk(2'd2, 6'h00), 32'h200);
        expect_only("R5 window inclusive", 3, 2);
        win_en = 1'b0;
        send(mk(2'd2, 6'h00), 32'h200);
        rd(3'd3, got); check("R5 window off", got, 3);

        // R6: write blocked while counting, accepted while stopped
        clear();
        prog(8'h02, 3'd1);
        send(mk(2'd0, 6'h02), 32'h0);
        expect_only("R6 write ignored while counting", 2, 1);
        count_en = 1'b0;
        prog(8'h02, 3'd1);
        count_en = 1'b1;
        clear();
        send(mk(2'd0, 6'h02), 32'h0);
        expect_only("R6 write taken while stopped", 1, 1);

        // R7: saturation
        clear();
        @(negedge clk);
        retire_valid = 1'b1; retire_instr = mk(2'd2, 6'h00); retire_pc = '0;
        repeat (70) @(negedge clk);
        retire_valid = 1'b0;
        expect_only("R7 saturate", 3, 32'(TB_MAX));

        // R8: clear wins over a simultaneous increment
        @(negedge clk);
        clr = 1'b1; retire_valid = 1'b1; retire_instr = mk(2'd2, 6'h00);
        @(negedge clk);
        clr = 1'b0; retire_valid = 1'b0;
        expect_only("R8 clear priority", 3, 0);

        // R9: read lags by one edge
        send(mk(2'd2, 6'h00), 32'h0);
        send(mk(2'd2, 6'h00), 32'h0);
        send(mk(2'd2, 6'h00), 32'h0);
        @(negedge clk);
        rd_sel = 3'd3; retire_valid = 1'b1; retire_instr = mk(2'd2, 6'h00);
        @(posedge clk);
        #1 check("R9 old value during increment", 32'(rd_data), 3);
        @(negedge clk); retire_valid = 1'b0;
        @(posedge clk);
        #1 check("R9 new value next edge", 32'(rd_data), 4);
        for (int s = 5; s < 8; s++) begin
            rd(3'(s), got);
            check("R9 void selector", got, 0);
        end

        summary();
    end
endmodule